// File: doc/BRIEF.md
# Software Watchdog Timer

This block is a countdown watchdog that is running as soon as reset is released. Software must keep it from expiring by writing a two-word key sequence to its service register. If the count runs out, the block raises one of two requests. One is a hard-reset request for the system reset controller. The other is an interrupt request for the interrupt controller. A mode bit picks which of the two is raised.

A single control register holds four settings:

- an enable bit;
- the timeout-action mode bit;
- a prescale bit, which makes the counter advance once every 2^PRE_W system clocks instead of on every clock;
- the count value that the counter reloads from.

The control register accepts exactly one write after reset. This lets software either disable the watchdog or fix its configuration, and nothing can change it afterwards.

With the default parameters and settings, the counter reloads from 0xFFFF and is prescaled by 65,536. The first timeout therefore comes about 2^32 clocks after reset.

Top module: `sw_watchdog`

## Requirements
- R1: After reset the control register reads 0xFFFF0007. Its fields are bit 0 enable = 1, bit 1 reset-mode = 1, bit 2 prescale = 1, and bits [31:16] reload = 0xFFFF. The count reads 0xFFFF. The counter then counts down with no software action: it decrements once every 2^PRE_W clocks.
- R2: In reset mode (bit 1 = 1), a timeout sets `resetReq`. It stays set until the block is reset.
- R3: In interrupt mode (bit 1 = 0), a timeout sets `irqReq` and `resetReq` stays low. The counter reloads and keeps counting. `irqReq` stays set until a valid service sequence.
- R4: With prescale = 1, the counter steps once every 2^PRE_W clocks. With reload N, the timeout is flagged 1 + 2^PRE_W·(N+1) clocks after the accepted control write.
- R5: With prescale = 0, the counter steps every clock. The clock after an accepted control write loads the reload value N. The timeout is flagged N+2 clocks after that write.
- R6: Writing 0x556C and then 0xAA39 to the service register (address 1, low 16 bits) is a valid service. It reloads the counter to N and clears the prescaler on the clock of the second write. The next timeout then comes N+1 steps later.
- R7: Any other value written between the two keys discards the first key. The second key then does not service the watchdog.
- R8: Only the first control write after reset takes effect. Later control writes leave the register's readback and the timeout behaviour unchanged.
- R9: While enable = 0, the count holds the reload value and neither request output asserts.
- R10: A read at address 0 returns the control register. A read at address 1 returns the current count in bits [15:0], with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 service/count |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the register selected by regAddr |
| resetReq | output | 1 | Hard-reset request, sticky until reset |
| irqReq | output | 1 | Interrupt request, held until a valid service |

## Verification
The hardest state to reach from the ports is a real timeout. With the default divide-by-65,536 prescaler and 0xFFFF reload, one takes billions of clocks. The bench therefore builds the block with a 3-bit prescaler and uses its one allowed control write to set a small reload value, so each timeout lands at an exactly predicted clock. Each scenario starts from a fresh reset, because the control register locks after one write. The key sequences are interleaved with a stray value and with repeated timeouts in interrupt mode. This shows that only a clean key pair reloads the counter and drops the interrupt.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  // Strobes from the control half to the counting half
  typedef struct packed {
    logic reload;    // load the reload value, clear the prescaler
    logic run;       // counting allowed
    logic prescale;  // step only on prescaler wrap
  } wdtStrobes_t;
endpackage

// File: rtl/wdt_count.sv
`timescale 1ns/1ps
module wdt_count
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobes_t      strb,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] preQ;
  logic [CNT_W-1:0] cntQ;
  logic             tick;

  assign tick   = !strb.prescale || (preQ == PRE_LAST);
  assign expire = strb.run && !strb.reload && tick && (cntQ == '0);
  assign cnt    = cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ <= '0;
      cntQ <= '1;
    end else if (strb.reload) begin
      preQ <= '0;
      cntQ <= reloadVal;
    end else if (strb.run) begin
      if (strb.prescale) preQ <= preQ + 1'b1;
      if (tick) cntQ <= (cntQ == '0) ? reloadVal : cntQ - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int          CNT_W  = 16,
  parameter int          DATA_W = 32,
  parameter logic [15:0] KEY_A  = 16'h556C,
  parameter logic [15:0] KEY_B  = 16'hAA39
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expire,
  output logic              enable,
  output logic              resetMode,
  output logic              prescaleOn,
  output logic [CNT_W-1:0]  reloadVal,
  output logic              locked,
  output logic              pendLoad,
  output logic              serviceOk,
  output wdtStrobes_t       strb,
  output logic              resetReq,
  output logic              irqReq
);
  localparam int RELOAD_LSB = 16;

  logic        ctrlWr, svcWr, armQ;
  logic [15:0] keyIn;

  assign keyIn     = wrData[15:0];
  assign ctrlWr    = wrEn && !wrAddr && !locked;
  assign svcWr     = wrEn && wrAddr;
  assign serviceOk = svcWr && armQ && (keyIn == KEY_B);

  always_comb begin
    strb.reload   = serviceOk || !enable || pendLoad;
    strb.run      = enable;
    strb.prescale = prescaleOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable     <= 1'b1;
      resetMode  <= 1'b1;
      prescaleOn <= 1'b1;
      reloadVal  <= '1;
      locked     <= 1'b0;
      pendLoad   <= 1'b0;
      armQ       <= 1'b0;
      resetReq   <= 1'b0;
      irqReq     <= 1'b0;
    end else begin
      pendLoad <= ctrlWr;
      if (ctrlWr) begin
        enable     <= wrData[0];
        resetMode  <= wrData[1];
        prescaleOn <= wrData[2];
        reloadVal  <= wrData[RELOAD_LSB +: CNT_W];
        locked     <= 1'b1;
      end
      if (svcWr) armQ <= (keyIn == KEY_A);
      if (expire && resetMode) resetReq <= 1'b1;
      if (serviceOk) irqReq <= 1'b0;
      else if (expire && !resetMode) irqReq <= 1'b1;
    end
  end
endmodule

// File: rtl/sw_watchdog.sv
`timescale 1ns/1ps
module sw_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              resetReq,
  output logic              irqReq
);
  localparam int RELOAD_LSB = 16;

  wdtStrobes_t      strb;
  logic             enable, resetMode, prescaleOn, locked, pendLoad, serviceOk, expire;
  logic [CNT_W-1:0] reloadVal, cnt;

  wdt_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) ctrlUnit (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrAddr(regAddr), .wrData(regWrData),
    .expire(expire), .enable(enable), .resetMode(resetMode), .prescaleOn(prescaleOn),
    .reloadVal(reloadVal), .locked(locked), .pendLoad(pendLoad), .serviceOk(serviceOk),
    .strb(strb), .resetReq(resetReq), .irqReq(irqReq)
  );

  wdt_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) countUnit (
    .clk(clk), .rstN(rstN), .strb(strb), .reloadVal(reloadVal),
    .cnt(cnt), .expire(expire)
  );

  always_comb begin
    regRdData = '0;
    if (!regAddr) begin
      regRdData[0] = enable;
      regRdData[1] = resetMode;
      regRdData[2] = prescaleOn;
      regRdData[RELOAD_LSB +: CNT_W] = reloadVal;
    end else begin
      regRdData[CNT_W-1:0] = cnt;
    end
  end
endmodule

// File: rtl/sw_watchdog_checker.sv
`timescale 1ns/1ps
module sw_watchdog_checker
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             resetMode,
  input logic             prescaleOn,
  input logic             locked,
  input logic             pendLoad,
  input logic             serviceOk,
  input logic [CNT_W-1:0] reloadVal,
  input logic [CNT_W-1:0] cnt,
  input logic             resetReq,
  input logic             irqReq
);
  assert_reset_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> resetReq);

  assert_irq_mode_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(!resetMode));

  assert_irq_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqReq) |-> $past(serviceOk));

  assert_service_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    serviceOk |=> (cnt == $past(reloadVal)));

  assert_ctrl_lock_R8: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable({enable, resetMode, prescaleOn, reloadVal}));

  assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !pendLoad) |=> ($stable(cnt) && !$rose(resetReq) && !$rose(irqReq)));
endmodule

bind sw_watchdog sw_watchdog_checker #(.CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .enable(enable), .resetMode(resetMode),
  .prescaleOn(prescaleOn), .locked(locked), .pendLoad(pendLoad),
  .serviceOk(serviceOk), .reloadVal(reloadVal), .cnt(cnt),
  .resetReq(resetReq), .irqReq(irqReq)
);

// File: tb/sw_watchdog_test.sv
`timescale 1ns/1ps
module sw_watchdog_test;
  localparam logic [31:0] KEY_A = 32'h556C;
  localparam logic [31:0] KEY_B = 32'hAA39;

  logic        clk = 0;
  logic        rstN = 0;
  logic        regWrEn = 0;
  logic        regAddr = 0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        resetReq, irqReq;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  sw_watchdog #(.CNT_W(16), .PRE_W(3), .DATA_W(32)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .resetReq(resetReq), .irqReq(irqReq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; regWrEn = 0; regAddr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  // Write lands on the returned-from edge; returns 1 ns after it
  task automatic wrReg(logic addr, logic [31:0] data);
    @(negedge clk);
    regWrEn = 1; regAddr = addr; regWrData = data;
    @(posedge clk);
    #1;
    regWrEn = 0;
  endtask

  task automatic rdReg(logic addr, output logic [31:0] data);
    regAddr = addr;
    #1;
    data = regRdData;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic testResetDefaults();
    logic [31:0] v;
    doReset();
    rdReg(0, v); chk("R1 ctrl default", v, 32'hFFFF_0007);
    rdReg(1, v); chk("R10 count default", v, 32'h0000_FFFF);
    chk("R1 no requests", {30'd0, resetReq, irqReq}, 32'd0);
    edges(20);
    rdReg(1, v); chk("R1 counts prescaled from reset", v, 32'h0000_FFFD);
  endtask

  task automatic testResetTimeout();
    logic [31:0] v;
    doReset();
    wrReg(0, 32'h0009_0003);
    edges(1);
    rdReg(1, v); chk("R5 reload loaded", v, 32'd9);
    edges(9);
    chk("R5 no timeout yet", {31'd0, resetReq}, 32'd0);
    edges(1);
    chk("R5 timeout at N+2", {31'd0, resetReq}, 32'd1);
    chk("R2 no irq in reset mode", {31'd0, irqReq}, 32'd0);
    edges(15);
    chk("R2 resetReq sticky", {31'd0, resetReq}, 32'd1);
  endtask

  task automatic testIrqMode();
    logic [31:0] v;
    doReset();
    wrReg(0, 32'h0005_0001);
    edges(6);
    chk("R3 irq low before timeout", {31'd0, irqReq}, 32'd0);
    edges(1);
    chk("R3 irq set", {31'd0, irqReq}, 32'd1);
    chk("R3 resetReq low", {31'd0, resetReq}, 32'd0);
    rdReg(1, v); chk("R3 reloaded on timeout", v, 32'd5);
    edges(1);
    rdReg(1, v); chk("R3 keeps running", v, 32'd4);
    edges(12);
    chk("R3 irq held", {31'd0, irqReq}, 32'd1);
    wrReg(1, KEY_A);
    chk("R3 irq held after first key", {31'd0, irqReq}, 32'd1);
    wrReg(1, KEY_B);
    chk("R3 irq cleared by service", {31'd0, irqReq}, 32'd0);
    rdReg(1, v); chk("R6 count reloaded by service", v, 32'd5);
  endtask

  task automatic testPrescale();
    doReset();
    wrReg(0, 32'h0002_0007);
    edges(24);
    chk("R4 no prescaled timeout yet", {31'd0, resetReq}, 32'd0);
    edges(1);
    chk("R4 prescaled timeout", {31'd0, resetReq}, 32'd1);
  endtask

  task automatic testService();
    logic [31:0] v;
    doReset();
    wrReg(0, 32'h0009_0003);
    for (int i = 0; i < 5; i++) begin
      edges(4);
      wrReg(1, KEY_A);
      wrReg(1, KEY_B);
    end
    chk("R6 serviced, no timeout", {31'd0, resetReq}, 32'd0);
    rdReg(1, v); chk("R6 count at reload", v, 32'd9);
    edges(9);
    chk("R6 no timeout before N+1 steps", {31'd0, resetReq}, 32'd0);
    edges(1);
    chk("R6 timeout N+1 steps after service", {31'd0, resetReq}, 32'd1);
  endtask

  task automatic testBadSequence();
    logic [31:0] v;
    doReset();
    wrReg(0, 32'h0009_0003);
    wrReg(1, KEY_A);
    wrReg(1, 32'h0000_1234);
    wrReg(1, KEY_B);
    rdReg(1, v); chk("R7 broken sequence no reload", v, 32'd7);
    edges(7);
    chk("R7 no early timeout", {31'd0, resetReq}, 32'd0);
    edges(1);
    chk("R7 timeout not prevented", {31'd0, resetReq}, 32'd1);
  endtask

  task automatic testDisable();
    logic [31:0] v;
    doReset();
    wrReg(0, 32'h0003_0000);
    edges(30);
    rdReg(1, v); chk("R9 count holds reload", v, 32'd3);
    chk("R9 no requests", {30'd0, resetReq, irqReq}, 32'd0);
    wrReg(0, 32'h0003_0003);
    rdReg(0, v); chk("R8 re-enable ignored", v, 32'h0003_0000);
    wrReg(1, KEY_A);
    wrReg(1, KEY_B);
    edges(20);
    rdReg(1, v); chk("R9 still held", v, 32'd3);
    chk("R9 still no requests", {30'd0, resetReq, irqReq}, 32'd0);
  endtask

  task automatic testLock();
    logic [31:0] v;
    doReset();
    wrReg(0, 32'h0009_0003);
    wrReg(0, 32'h0028_0005);
    rdReg(0, v); chk("R8 second write ignored", v, 32'h0009_0003);
    edges(9);
    chk("R8 timing unchanged, low", {31'd0, resetReq}, 32'd0);
    edges(1);
    chk("R8 reset-mode timeout kept", {31'd0, resetReq}, 32'd1);
    chk("R8 no irq", {31'd0, irqReq}, 32'd0);
  endtask

  initial begin
    testResetDefaults();
    testResetTimeout();
    testIrqMode();
    testPrescale();
    testService();
    testBadSequence();
    testDisable();
    testLock();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule